// File: doc/BRIEF.md
# Byte-Lane Static RAM Model

This block is a synthesizable, clock-sampled behavioural model of a 16-bit wide asynchronous static RAM that is split into two independently enabled byte lanes. Its control pins are all active low: chip select, write strobe, output enable, and one enable for each byte lane. A simulation clock samples the pins. Each sample is sorted into one of five operating modes: deselected, no lane enabled, write, read, or selected with outputs off. The mode then sets which lanes drive read data, which bytes a write updates, and whether the part reports standby or active power.

The model replaces the chip's shared data pins with three signals: a data input, a data output, and one output-drive flag for each lane. A board-level wrapper can rebuild the tristate bus from these. The full array is 2^17 words. A depth parameter lets simulation use a smaller array, and the address bits above that depth are then ignored, so higher addresses alias onto the smaller array. Analog timing, electrical levels and data-retention supply behaviour are not modelled. All control and data pins are plain level signals with no valid/ready handshake, because the part being modelled never applies back-pressure.

Top module: `byte_sram_model`

## Requirements
- R1: A word written at an address reads back unchanged at that address. Only the low `MEM_AW` address bits select a word (default 10), so an address and that address plus 2^`MEM_AW` refer to the same word.
- R2: A write is the overlap of `cs_n` low and `we_n` low. It commits at the clock edge after the first sample in which the overlap has ended. It uses the address, data and lane enables from the last sample inside the overlap. A read sampled in the cycle the overlap ends still returns the old word, and the next read sample returns the new one.
- R3: `lb_n` low during a write updates data bits 7:0, and `ub_n` low updates bits 15:8. A lane whose enable is high keeps its previous byte.
- R4: A sample with `cs_n` low, `we_n` high and `oe_n` low is a read. `dout_en[0]` is the inverse of `lb_n` and `dout_en[1]` is the inverse of `ub_n`. The outputs reflect the pins sampled at the previous clock edge.
- R5: `dout_en` is 2'b00 when `cs_n` is high, when `oe_n` is high, when both lane enables are high, or when `we_n` is low. A byte of `dout` whose drive flag is 0 reads as zero.
- R6: `standby` is 1 when `cs_n` is high, or when `cs_n` is low with both lane enables high. It is 0 in every other case, including selected with outputs disabled.
- R7: When `we_n` is low, the level of `oe_n` has no effect: the write is stored and no lane drives.
- R8: While reset is applied and in the first cycle after it, `standby` is 1 and `dout_en` is 2'b00, and no write commits.
- R9: A write strobe with both lane enables high, or with `cs_n` high, leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset of the pin samplers |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte lane enable (bits 7:0), active low |
| ub_n | input | 1 | Upper byte lane enable (bits 15:8), active low |
| addr | input | ADDR_W (17) | Word address |
| din | input | DATA_W (16) | Write data, the input side of the data bus |
| dout | output | DATA_W (16) | Read data, the output side of the data bus; undriven bytes are zero |
| dout_en | output | 2 | Per-lane drive flag, bit 0 lower byte, bit 1 upper byte |
| standby | output | 1 | Power mode: 1 standby, 0 active |

## Verification
Full-word, lower-only and upper-only writes to one address separate correct byte masking from whole-word overwrites. Reads with each lane-enable combination check that the drive flags and the zeroed bytes follow the right pin. Writes held over several cycles, with data or address changing inside the overlap and the write ended either by the strobe or by the chip select, show that the last in-overlap sample is the one stored and show the exact cycle in which the new data becomes visible. A walk through every control row checks the power flag, and writes with no lane enabled or with the chip deselected show that the array is left untouched. A write at an address above the reduced depth, read back from the low address, shows the aliasing.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  localparam int LANE_BITS = 8;
  localparam int LANE_CNT  = 2;

  // One sample of the active-low control pins; lane_n[0] is the lower byte.
  typedef struct packed {
    logic                cs_n;
    logic                we_n;
    logic                oe_n;
    logic [LANE_CNT-1:0] lane_n;
  } pins_t;

  typedef enum logic [2:0] {
    M_DESEL  = 3'd0,
    M_NOLANE = 3'd1,
    M_WRITE  = 3'd2,
    M_READ   = 3'd3,
    M_OUTOFF = 3'd4
  } mode_e;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                  lane_n: {LANE_CNT{1'b1}}};

endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int MEM_AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pins_t               pins_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   din_i,
  output pins_t               cur_pins_o,
  output logic [MEM_AW-1:0]   cur_idx_o,
  output logic                prev_wr_o,
  output logic [LANE_CNT-1:0] prev_lane_n_o,
  output logic [MEM_AW-1:0]   prev_idx_o,
  output logic [DATA_W-1:0]   prev_din_o
);

  pins_t             cur_q;
  logic [MEM_AW-1:0] cur_idx_q;
  logic [DATA_W-1:0] cur_din_q;
  logic              cur_wr;

  // Upper address bits only alias onto the reduced array.
  generate
    if (MEM_AW < ADDR_W) begin : g_alias
      logic addr_hi_unused;
      assign addr_hi_unused = ^addr_i[ADDR_W-1:MEM_AW];
    end
  endgenerate

  // First stage: the pins as seen at this edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= PINS_IDLE;
      cur_idx_q <= '0;
      cur_din_q <= '0;
    end else begin
      cur_q     <= pins_i;
      cur_idx_q <= addr_i[MEM_AW-1:0];
      cur_din_q <= din_i;
    end
  end

  assign cur_wr = !cur_q.cs_n && !cur_q.we_n;

  // Second stage: the write-relevant part of the previous sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_wr_o     <= 1'b0;
      prev_lane_n_o <= '1;
      prev_idx_o    <= '0;
      prev_din_o    <= '0;
    end else begin
      prev_wr_o     <= cur_wr;
      prev_lane_n_o <= cur_q.lane_n;
      prev_idx_o    <= cur_idx_q;
      prev_din_o    <= cur_din_q;
    end
  end

  assign cur_pins_o = cur_q;
  assign cur_idx_o  = cur_idx_q;

endmodule

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
  import sram_model_pkg::*;
(
  input  pins_t               cur_pins_i,
  input  logic                prev_wr_i,
  input  logic [LANE_CNT-1:0] prev_lane_n_i,
  output logic                standby_o,
  output logic [LANE_CNT-1:0] drive_o,
  output logic [LANE_CNT-1:0] lane_we_o
);

  mode_e mode;
  logic  cur_wr;
  logic  commit;

  // Precedence follows the truth table: select, then lanes, then strobe.
  always_comb begin
    if (cur_pins_i.cs_n)                mode = M_DESEL;
    else if (&cur_pins_i.lane_n)        mode = M_NOLANE;
    else if (!cur_pins_i.we_n)          mode = M_WRITE;
    else if (!cur_pins_i.oe_n)          mode = M_READ;
    else                                mode = M_OUTOFF;
  end

  assign standby_o = (mode == M_DESEL) || (mode == M_NOLANE);

  // Overlap ends when the current sample no longer has both strobes low.
  assign cur_wr = !cur_pins_i.cs_n && !cur_pins_i.we_n;
  assign commit = prev_wr_i && !cur_wr;

  generate
    for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
      assign drive_o[g]   = (mode == M_READ) && !cur_pins_i.lane_n[g];
      assign lane_we_o[g] = commit && !prev_lane_n_i[g];
    end
  endgenerate

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_model_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic                          clk,
  input  logic [LANE_CNT-1:0]           we_i,
  input  logic [MEM_AW-1:0]             widx_i,
  input  logic [LANE_CNT*LANE_BITS-1:0] wdata_i,
  input  logic [MEM_AW-1:0]             ridx_i,
  output logic [LANE_CNT*LANE_BITS-1:0] rdata_o
);

  localparam int DEPTH = 1 << MEM_AW;

  generate
    for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
      logic [LANE_BITS-1:0] mem_q [DEPTH];

      always_ff @(posedge clk) begin
        if (we_i[g]) mem_q[widx_i] <= wdata_i[g*LANE_BITS +: LANE_BITS];
      end

      assign rdata_o[g*LANE_BITS +: LANE_BITS] = mem_q[ridx_i];
    end
  endgenerate

endmodule

// File: rtl/byte_sram_model.sv
module byte_sram_model
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = LANE_CNT * LANE_BITS,
  parameter int MEM_AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic                lb_n,
  input  logic                ub_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   dout,
  output logic [LANE_CNT-1:0] dout_en,
  output logic                standby
);

  pins_t               pins_in;
  pins_t               cur_pins;
  logic [MEM_AW-1:0]   cur_idx;
  logic                prev_wr;
  logic [LANE_CNT-1:0] prev_lane_n;
  logic [MEM_AW-1:0]   prev_idx;
  logic [DATA_W-1:0]   prev_din;
  logic [LANE_CNT-1:0] drive;
  logic [LANE_CNT-1:0] lane_we;
  logic [DATA_W-1:0]   rdata;

  assign pins_in = '{cs_n: cs_n, we_n: we_n, oe_n: oe_n, lane_n: {ub_n, lb_n}};

  sram_pin_sampler #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MEM_AW (MEM_AW)
  ) u_sampler (
    .clk           (clk),
    .rst_n         (rst_n),
    .pins_i        (pins_in),
    .addr_i        (addr),
    .din_i         (din),
    .cur_pins_o    (cur_pins),
    .cur_idx_o     (cur_idx),
    .prev_wr_o     (prev_wr),
    .prev_lane_n_o (prev_lane_n),
    .prev_idx_o    (prev_idx),
    .prev_din_o    (prev_din)
  );

  sram_ctrl_decode u_decode (
    .cur_pins_i    (cur_pins),
    .prev_wr_i     (prev_wr),
    .prev_lane_n_i (prev_lane_n),
    .standby_o     (standby),
    .drive_o       (drive),
    .lane_we_o     (lane_we)
  );

  sram_lane_array #(
    .MEM_AW (MEM_AW)
  ) u_array (
    .clk     (clk),
    .we_i    (lane_we),
    .widx_i  (prev_idx),
    .wdata_i (prev_din),
    .ridx_i  (cur_idx),
    .rdata_o (rdata)
  );

  generate
    for (genvar g = 0; g < LANE_CNT; g++) begin : g_out
      assign dout[g*LANE_BITS +: LANE_BITS] =
        drive[g] ? rdata[g*LANE_BITS +: LANE_BITS] : '0;
    end
  endgenerate

  assign dout_en = drive;

  // R5: no lane drives while the power flag says standby.
  a_r5_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (dout_en == '0));

  // R5 / R7: a sampled write overlap never drives, whatever oe_n is.
  a_r7_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_pins.cs_n && !cur_pins.we_n) |-> (dout_en == '0));

  // R6: selected with outputs off is active and quiet.
  a_r6_outoff_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_pins.cs_n && cur_pins.we_n && cur_pins.oe_n && !(&cur_pins.lane_n))
      |-> (!standby && dout_en == '0));

  // R2: a commit is a single-cycle pulse.
  a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |=> (lane_we == '0));

  // R2: a commit only follows a sampled overlap that has now ended.
  a_r2_commit_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |-> (prev_wr && !(!cur_pins.cs_n && !cur_pins.we_n)));

  // R9: lanes held high through the final overlap sample are never written.
  a_r9_masked_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we & prev_lane_n) == '0);

endmodule

// File: tb/byte_sram_model_bench.sv
module byte_sram_model_bench;

  localparam int ADDR_W = 17;
  localparam int DATA_W = 16;
  localparam int MEM_AW = 10;
  localparam int WRAP   = 1 << MEM_AW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs_n, we_n, oe_n, lb_n, ub_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] din;
  logic [DATA_W-1:0] dout;
  logic [1:0]        dout_en;
  logic              standby;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  byte_sram_model #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MEM_AW (MEM_AW)
  ) u_byte_sram_model (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .lb_n    (lb_n),
    .ub_n    (ub_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_en (dout_en),
    .standby (standby)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a negedge: set pins, then wait until the next negedge,
  // by which point the sampling edge has passed and outputs reflect them.
  task automatic apply(bit c, bit w, bit o, bit u, bit l,
                       logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    cs_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = l; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic idle();
    apply(1, 1, 1, 1, 1, '0, '0);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, bit u, bit l, bit o);
    apply(0, 0, o, u, l, a, d);
    idle();
    idle();
  endtask

  task automatic rd(string req, logic [ADDR_W-1:0] a, bit u, bit l,
                    logic [DATA_W-1:0] exp_d, logic [1:0] exp_en);
    apply(0, 1, 0, u, l, a, '0);
    check(req, "dout", dout, exp_d);
    check(req, "dout_en", dout_en, exp_en);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cs_n = 1; we_n = 1; oe_n = 1; lb_n = 1; ub_n = 1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    check("R8", "standby in reset", standby, 1'b1);
    check("R8", "dout_en in reset", dout_en, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "standby after reset", standby, 1'b1);
    check("R8", "dout_en after reset", dout_en, 2'b00);
  endtask

  task automatic t_masked_write();
    wr(17'd5, 16'hA5C3, 0, 0, 1);
    rd("R1", 17'd5, 0, 0, 16'hA5C3, 2'b11);
    check("R4", "standby on read", standby, 1'b0);
    rd("R4", 17'd5, 1, 0, 16'h00C3, 2'b01);
    rd("R4", 17'd5, 0, 1, 16'hA500, 2'b10);
    wr(17'd5, 16'h1111, 1, 0, 1);
    rd("R3", 17'd5, 0, 0, 16'hA511, 2'b11);
    wr(17'd5, 16'h2222, 0, 1, 1);
    rd("R3", 17'd5, 0, 0, 16'h2211, 2'b11);
    idle();
  endtask

  task automatic t_commit_timing();
    wr(17'd20, 16'h1234, 0, 0, 1);
    apply(0, 0, 1, 0, 0, 17'd20, 16'hBEEF);
    apply(0, 1, 0, 0, 0, 17'd20, '0);
    check("R2", "old data in end cycle", dout, 16'h1234);
    apply(0, 1, 0, 0, 0, 17'd20, '0);
    check("R2", "new data next cycle", dout, 16'hBEEF);
    idle();
    // Data changes inside a held overlap: last sample wins.
    apply(0, 0, 1, 0, 0, 17'd40, 16'hAAAA);
    apply(0, 0, 1, 0, 0, 17'd40, 16'h5555);
    idle();
    idle();
    rd("R2", 17'd40, 0, 0, 16'h5555, 2'b11);
    // Address moves inside the overlap; chip select ends it.
    wr(17'd30, 16'h0F0F, 0, 0, 1);
    wr(17'd31, 16'h7070, 0, 0, 1);
    apply(0, 0, 1, 0, 0, 17'd30, 16'h1111);
    apply(0, 0, 1, 0, 0, 17'd31, 16'h2222);
    apply(1, 0, 1, 0, 0, 17'd31, 16'h3333);
    idle();
    rd("R2", 17'd30, 0, 0, 16'h0F0F, 2'b11);
    rd("R2", 17'd31, 0, 0, 16'h2222, 2'b11);
    idle();
  endtask

  task automatic t_oe_ignored();
    apply(0, 0, 0, 0, 0, 17'd50, 16'h6A6A);
    check("R7", "no drive with oe low in write", dout_en, 2'b00);
    check("R7", "dout zero in write", dout, 16'h0000);
    check("R6", "write is active", standby, 1'b0);
    idle();
    idle();
    rd("R7", 17'd50, 0, 0, 16'h6A6A, 2'b11);
    idle();
  endtask

  task automatic t_no_write();
    apply(0, 0, 1, 1, 1, 17'd5, 16'hFFFF);
    check("R6", "write with no lane is standby", standby, 1'b1);
    idle();
    idle();
    rd("R9", 17'd5, 0, 0, 16'h2211, 2'b11);
    apply(1, 0, 1, 0, 0, 17'd5, 16'hFFFF);
    idle();
    idle();
    rd("R9", 17'd5, 0, 0, 16'h2211, 2'b11);
    idle();
  endtask

  task automatic t_hiz();
    apply(1, 1, 0, 0, 0, 17'd5, '0);
    check("R5", "deselected drive", dout_en, 2'b00);
    check("R5", "deselected data", dout, 16'h0000);
    apply(0, 1, 1, 0, 0, 17'd5, '0);
    check("R5", "oe high drive", dout_en, 2'b00);
    check("R5", "oe high data", dout, 16'h0000);
    apply(0, 1, 0, 1, 1, 17'd5, '0);
    check("R5", "no lane drive", dout_en, 2'b00);
    idle();
  endtask

  task automatic t_power_table();
    apply(1, 1, 0, 0, 0, 17'd7, '0);
    check("R6", "cs high", standby, 1'b1);
    apply(1, 0, 1, 0, 0, 17'd7, '0);
    check("R6", "cs high we low", standby, 1'b1);
    apply(0, 1, 0, 1, 1, 17'd7, '0);
    check("R6", "cs low lanes off", standby, 1'b1);
    for (int k = 0; k < 3; k++) begin
      apply(0, 1, 0, k[1], k[0], 17'd7, '0);
      check("R6", "read row", standby, 1'b0);
      apply(0, 1, 1, k[1], k[0], 17'd7, '0);
      check("R6", "outputs-off row", standby, 1'b0);
      check("R6", "outputs-off drive", dout_en, 2'b00);
    end
    for (int k = 0; k < 3; k++) begin
      apply(0, 0, 1, k[1], k[0], 17'd7, '0);
      check("R6", "write row", standby, 1'b0);
    end
    idle();
    idle();
  endtask

  task automatic t_alias();
    wr(17'd9, 16'hC0DE, 0, 0, 1);
    rd("R1", 17'(9 + WRAP), 0, 0, 16'hC0DE, 2'b11);
    wr(17'(11 + 5 * WRAP), 16'h4242, 0, 0, 1);
    rd("R1", 17'd11, 0, 0, 16'h4242, 2'b11);
    idle();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_masked_write();
    t_commit_timing();
    t_oe_ignored();
    t_no_write();
    t_hiz();
    t_power_table();
    t_alias();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule